// File: doc/BRIEF.md
# Exception vector fetch sequencer

This block performs the closing step of exception entry in a 32-bit processor core. An exception request brings an 8-bit vector number and a class flag that says whether it is an interrupt or a task-related exception. The class decides which supervisor stack pointer the core uses. A task-related exception uses the master stack pointer while the mode bit is set. An interrupt clears the mode bit and uses the interrupt stack pointer. Apart from that choice, every exception is handled the same way.

The vector table sits at a relocatable base register. Each entry is four bytes wide, so the table address is the base plus the vector number shifted left by two. The block reads the 32-bit entry over a simple memory read port that has a ready signal and an error response. It loads the value read as the new program counter and then pulses a fetch request so that decoding resumes there. If the read returns an error, the block raises a fault pulse instead and keeps the old program counter. The base register and the mode bit can be written while the block is idle.

Top module: `exc_vector_seq`

## Requirements
- R1: In reset and just after it, `busy`, `mem_rd_req`, `fetch_req`, `fault`, `mode_bit` and `sp_select` are 0, and `pc_out` is 0. The base register also resets to 0.
- R2: A task-related request (`req_is_irq`=0) accepted while `mode_bit`=1 drives `sp_select`=1 (master stack pointer) from the next cycle, and `mode_bit` stays 1.
- R3: An interrupt request (`req_is_irq`=1) clears `mode_bit` and drives `sp_select`=0 (interrupt stack pointer), both from the cycle after acceptance.
- R4: A task-related request accepted while `mode_bit`=0 drives `sp_select`=0 and leaves `mode_bit` at 0.
- R5: `mem_rd_req` rises two cycles after acceptance. It stays high, with `mem_rd_addr` stable, until a cycle with `mem_rd_ready`=1. `mem_rd_addr` equals base + vector*4, modulo 2^32.
- R6: A ready cycle with `mem_rd_err`=0 loads `mem_rd_data` into `pc_out` by the next cycle. In that next cycle `fetch_req` is high for exactly one cycle, and the cycle after it `busy` is 0.
- R7: A ready cycle with `mem_rd_err`=1 gives `fault`=1 for exactly the next cycle, with `busy`=0 and `pc_out` unchanged. `fetch_req` does not pulse.
- R8: `busy` is 1 from the cycle after acceptance until the sequence ends. `req_valid` is ignored while `busy`=1.
- R9: `vbr_we`/`vbr_wdata` and `mode_we`/`mode_wdata` take effect on the next cycle when `busy`=0 and no request is accepted in the same cycle. In any other cycle they are ignored.
- R10: `sp_select` does not change while `busy` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request, accepted when busy is 0 |
| req_vector | input | 8 | Vector number of the request |
| req_is_irq | input | 1 | 1 = interrupt, 0 = task-related exception |
| vbr_we | input | 1 | Base register write strobe |
| vbr_wdata | input | 32 | Base register write value |
| mode_we | input | 1 | Mode bit write strobe |
| mode_wdata | input | 1 | Mode bit write value |
| mem_rd_req | output | 1 | Vector read request |
| mem_rd_addr | output | 32 | Vector read byte address |
| mem_rd_ready | input | 1 | Read completes this cycle |
| mem_rd_data | input | 32 | Read data |
| mem_rd_err | input | 1 | Bus error response with ready |
| busy | output | 1 | Sequence in progress |
| mode_bit | output | 1 | Current master/interrupt mode bit |
| sp_select | output | 1 | 1 = master stack pointer, 0 = interrupt stack pointer |
| pc_out | output | 32 | Program counter |
| fetch_req | output | 1 | One-cycle request to fetch at pc_out |
| fault | output | 1 | One-cycle vector read fault |

## Verification
The assertions assume that the memory side raises `mem_rd_ready` only while `mem_rd_req` is high, and that `mem_rd_err` counts only together with ready. They also assume that inputs are stable around the rising edge. The stimulus drives every input on the falling edge and gives ready only after it has seen the read request, with latencies from zero to several cycles. It places register writes and extra requests on purpose in busy cycles and in the acceptance cycle, so that the ignore rules in R8 and R9 are exercised without breaking those assumptions.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
   typedef enum logic [1:0] {
      ST_IDLE        = 2'd0,
      ST_SELECT_SP   = 2'd1,
      ST_READ_VECTOR = 2'd2,
      ST_LOAD_PC     = 2'd3
   } exc_state_e;
endpackage

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
   import exc_vec_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       rd_ready,
   input  logic       rd_err,
   output exc_state_e state,
   output logic       accept,
   output logic       pc_load,
   output logic       fault_q
);
   exc_state_e nxt;

   assign accept  = (state == ST_IDLE) && req_valid;
   assign pc_load = (state == ST_READ_VECTOR) && rd_ready && !rd_err;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:        if (req_valid) nxt = ST_SELECT_SP;
         ST_SELECT_SP:   nxt = ST_READ_VECTOR;
         ST_READ_VECTOR: if (rd_ready) nxt = rd_err ? ST_IDLE : ST_LOAD_PC;
         ST_LOAD_PC:     nxt = ST_IDLE;
         default:        nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         fault_q <= 1'b0;
      end else begin
         state   <= nxt;
         fault_q <= (state == ST_READ_VECTOR) && rd_ready && rd_err;
      end
   end
endmodule

// File: rtl/exc_mode_ctrl.sv
module exc_mode_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic idle,
   input  logic accept,
   input  logic is_irq,
   input  logic mode_we,
   input  logic mode_wdata,
   output logic mode_bit,
   output logic sp_sel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_bit <= 1'b0;
         sp_sel   <= 1'b0;
      end else if (accept) begin
         if (is_irq) begin
            mode_bit <= 1'b0;
            sp_sel   <= 1'b0;
         end else begin
            sp_sel   <= mode_bit;
         end
      end else if (idle && mode_we) begin
         mode_bit <= mode_wdata;
      end
   end
endmodule

// File: rtl/exc_vec_addr.sv
module exc_vec_addr #(
   parameter int          ADDR_W      = 32,
   parameter int          VEC_W       = 8,
   parameter int          ENTRY_BYTES = 4,
   parameter bit          RELOCATABLE = 1'b1,
   parameter logic [31:0] BASE_RESET  = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle,
   input  logic              accept,
   input  logic [VEC_W-1:0]  vector,
   input  logic              base_we,
   input  logic [ADDR_W-1:0] base_wdata,
   output logic [ADDR_W-1:0] vec_addr
);
   localparam int SHIFT = $clog2(ENTRY_BYTES);

   logic [VEC_W-1:0]  vec_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] offset;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vec_q <= '0;
      else if (accept) vec_q <= vector;
   end

   generate
      if (RELOCATABLE) begin : g_reloc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) base_q <= ADDR_W'(BASE_RESET);
            else if (idle && !accept && base_we) base_q <= base_wdata;
         end
      end else begin : g_fixed
         logic unused_wr;
         assign unused_wr = base_we ^ (^base_wdata) ^ clk ^ rst_n;
         assign base_q    = ADDR_W'(BASE_RESET);
      end
   endgenerate

   assign offset   = ADDR_W'(vec_q) << SHIFT;
   assign vec_addr = base_q + offset;
endmodule

// File: rtl/exc_vector_seq.sv
module exc_vector_seq
   import exc_vec_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int VEC_W       = 8,
   parameter int ENTRY_BYTES = 4,
   parameter bit RELOCATABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VEC_W-1:0]  req_vector,
   input  logic              req_is_irq,
   input  logic              vbr_we,
   input  logic [ADDR_W-1:0] vbr_wdata,
   input  logic              mode_we,
   input  logic              mode_wdata,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_ready,
   input  logic [DATA_W-1:0] mem_rd_data,
   input  logic              mem_rd_err,
   output logic              busy,
   output logic              mode_bit,
   output logic              sp_select,
   output logic [DATA_W-1:0] pc_out,
   output logic              fetch_req,
   output logic              fault
);
   generate
      if (ENTRY_BYTES < 1 || (ENTRY_BYTES & (ENTRY_BYTES - 1)) != 0) begin : g_bad_entry
         $error("ENTRY_BYTES must be a power of two");
      end
      if (ADDR_W < VEC_W + $clog2(ENTRY_BYTES)) begin : g_bad_addr
         $error("ADDR_W too narrow for vector table");
      end
      if (DATA_W < 1 || ADDR_W < 1 || VEC_W < 1) begin : g_bad_w
         $error("widths must be positive");
      end
   endgenerate

   exc_state_e state;
   logic       accept, pc_load, idle;

   assign idle = (state == ST_IDLE);

   exc_seq_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .rd_ready (mem_rd_ready),
      .rd_err   (mem_rd_err),
      .state    (state),
      .accept   (accept),
      .pc_load  (pc_load),
      .fault_q  (fault)
   );

   exc_mode_ctrl u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle      (idle),
      .accept    (accept),
      .is_irq    (req_is_irq),
      .mode_we   (mode_we),
      .mode_wdata(mode_wdata),
      .mode_bit  (mode_bit),
      .sp_sel    (sp_select)
   );

   exc_vec_addr #(
      .ADDR_W     (ADDR_W),
      .VEC_W      (VEC_W),
      .ENTRY_BYTES(ENTRY_BYTES),
      .RELOCATABLE(RELOCATABLE),
      .BASE_RESET (32'h0)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle      (idle),
      .accept    (accept),
      .vector    (req_vector),
      .base_we   (vbr_we),
      .base_wdata(vbr_wdata),
      .vec_addr  (mem_rd_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_out <= '0;
      else if (pc_load) pc_out <= mem_rd_data;
   end

   assign busy       = !idle;
   assign mem_rd_req = (state == ST_READ_VECTOR);
   assign fetch_req  = (state == ST_LOAD_PC);
endmodule

// File: rtl/exc_vector_seq_chk.sv
module exc_vector_seq_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_is_irq,
   input logic              busy,
   input logic              mode_bit,
   input logic              sp_select,
   input logic              mem_rd_req,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_rd_ready,
   input logic [DATA_W-1:0] mem_rd_data,
   input logic              mem_rd_err,
   input logic [DATA_W-1:0] pc_out,
   input logic              fetch_req,
   input logic              fault
);
   assert_task_msp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && !req_is_irq && mode_bit) |=> (sp_select && mode_bit));

   assert_irq_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_is_irq) |=> (!mode_bit && !sp_select));

   assert_task_isp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && !req_is_irq && !mode_bit) |=> (!sp_select && !mode_bit));

   assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_ready) |=> (mem_rd_req && $stable(mem_rd_addr)));

   assert_pc_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && mem_rd_ready && !mem_rd_err) |=> (fetch_req && pc_out == $past(mem_rd_data)));

   assert_fetch_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |=> (!fetch_req && !busy));

   assert_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && mem_rd_ready && mem_rd_err) |=> (fault && !busy && !fetch_req && $stable(pc_out)));

   assert_sp_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sp_select));
endmodule

bind exc_vector_seq exc_vector_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_is_irq  (req_is_irq),
   .busy        (busy),
   .mode_bit    (mode_bit),
   .sp_select   (sp_select),
   .mem_rd_req  (mem_rd_req),
   .mem_rd_addr (mem_rd_addr),
   .mem_rd_ready(mem_rd_ready),
   .mem_rd_data (mem_rd_data),
   .mem_rd_err  (mem_rd_err),
   .pc_out      (pc_out),
   .fetch_req   (fetch_req),
   .fault       (fault)
);

// File: tb/tb_exc_vector_seq.sv
module tb_exc_vector_seq;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_vector = '0;
   logic        req_is_irq = 1'b0;
   logic        vbr_we = 1'b0;
   logic [31:0] vbr_wdata = '0;
   logic        mode_we = 1'b0;
   logic        mode_wdata = 1'b0;
   logic        mem_rd_req;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_ready = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        mem_rd_err = 1'b0;
   logic        busy, mode_bit, sp_select, fetch_req, fault;
   logic [31:0] pc_out;

   exc_vector_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
      .req_is_irq(req_is_irq), .vbr_we(vbr_we), .vbr_wdata(vbr_wdata),
      .mode_we(mode_we), .mode_wdata(mode_wdata), .mem_rd_req(mem_rd_req),
      .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
      .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err), .busy(busy),
      .mode_bit(mode_bit), .sp_select(sp_select), .pc_out(pc_out),
      .fetch_req(fetch_req), .fault(fault)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int          m_phase = 0;   // 0 idle, 1 choosing stack, 2 reading, 3 restart
   int          m_vec   = 0;
   logic [31:0] m_base  = '0;
   logic        m_mode  = 1'b0;
   logic        m_sp    = 1'b0;
   logic [31:0] m_pc    = '0;
   logic        m_fault = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_vec = 0; m_base = '0; m_mode = 1'b0;
         m_sp = 1'b0; m_pc = '0; m_fault = 1'b0;
      end else begin
         m_fault = 1'b0;
         if (m_phase == 0) begin
            if (req_valid) begin
               m_vec = int'(req_vector);
               if (req_is_irq) begin m_mode = 1'b0; m_sp = 1'b0; end
               else m_sp = m_mode;
               m_phase = 1;
            end else begin
               if (vbr_we)  m_base = vbr_wdata;
               if (mode_we) m_mode = mode_wdata;
            end
         end else if (m_phase == 1) begin
            m_phase = 2;
         end else if (m_phase == 2) begin
            if (mem_rd_ready) begin
               if (mem_rd_err) begin m_fault = 1'b1; m_phase = 0; end
               else begin m_pc = mem_rd_data; m_phase = 3; end
            end
         end else begin
            m_phase = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8 busy", 32'(busy), 32'(m_phase != 0));
         chk("R10 sp_select", 32'(sp_select), 32'(m_sp));
         chk("R9 mode_bit", 32'(mode_bit), 32'(m_mode));
         chk("R5 mem_rd_req", 32'(mem_rd_req), 32'(m_phase == 2));
         if (m_phase == 2)
            chk("R5 mem_rd_addr", mem_rd_addr, m_base + 32'(m_vec) * 32'd4);
         chk("R6 pc_out", pc_out, m_pc);
         chk("R6 fetch_req", 32'(fetch_req), 32'(m_phase == 3));
         chk("R7 fault", 32'(fault), 32'(m_fault));
      end
   end

   task automatic reg_write(input logic [31:0] base, input logic mode);
      @(negedge clk);
      vbr_we = 1'b1; vbr_wdata = base; mode_we = 1'b1; mode_wdata = mode;
      @(negedge clk);
      vbr_we = 1'b0; mode_we = 1'b0;
   endtask

   task automatic run_exc(input logic [7:0] vec, input logic irq, input int lat,
                          input logic [31:0] data, input logic err,
                          input string tag, input logic exp_sp, input logic exp_mode,
                          input logic poke_busy, input logic wr_with_req);
      @(negedge clk);
      req_valid = 1'b1; req_vector = vec; req_is_irq = irq;
      if (wr_with_req) begin
         vbr_we = 1'b1; vbr_wdata = 32'hAAAA_0000; mode_we = 1'b1; mode_wdata = ~mode_bit;
      end
      @(negedge clk);
      req_valid = 1'b0; vbr_we = 1'b0; mode_we = 1'b0;
      chk({tag, " sp_select"}, 32'(sp_select), 32'(exp_sp));
      chk({tag, " mode_bit"}, 32'(mode_bit), 32'(exp_mode));
      if (poke_busy) begin
         req_valid = 1'b1; req_vector = 8'h77; req_is_irq = ~irq;
         vbr_we = 1'b1; vbr_wdata = 32'h5555_0000; mode_we = 1'b1; mode_wdata = ~mode_bit;
      end
      @(negedge clk);
      req_valid = 1'b0; vbr_we = 1'b0; mode_we = 1'b0;
      for (int i = 0; i < lat; i++) @(negedge clk);
      mem_rd_ready = 1'b1; mem_rd_data = data; mem_rd_err = err;
      @(negedge clk);
      mem_rd_ready = 1'b0; mem_rd_err = 1'b0; mem_rd_data = '0;
      if (err) chk("R7 fault pulse", 32'(fault), 32'd1);
      else     chk("R6 fetch pulse", 32'(fetch_req), 32'd1);
      @(negedge clk);
      chk("R8 idle after sequence", 32'(busy), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy", 32'(busy), 32'd0);
      chk("R1 mem_rd_req", 32'(mem_rd_req), 32'd0);
      chk("R1 fetch_req", 32'(fetch_req), 32'd0);
      chk("R1 fault", 32'(fault), 32'd0);
      chk("R1 mode_bit", 32'(mode_bit), 32'd0);
      chk("R1 sp_select", 32'(sp_select), 32'd0);
      chk("R1 pc_out", pc_out, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // base zero after reset: vector 3 read at 0x0C
      run_exc(8'h03, 1'b0, 0, 32'h0000_0100, 1'b0, "R4", 1'b0, 1'b0, 1'b0, 1'b0);
      reg_write(32'h0000_1000, 1'b1);
      run_exc(8'h05, 1'b0, 0, 32'hDEAD_BEEC, 1'b0, "R2", 1'b1, 1'b1, 1'b0, 1'b0);
      run_exc(8'h40, 1'b1, 3, 32'h1234_5678, 1'b0, "R3", 1'b0, 1'b0, 1'b1, 1'b0);
      run_exc(8'h20, 1'b0, 1, 32'h0BAD_F00D, 1'b0, "R4", 1'b0, 1'b0, 1'b1, 1'b0);
      run_exc(8'h02, 1'b0, 2, 32'hFFFF_FFFF, 1'b1, "R4", 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R7 pc kept", pc_out, 32'h0BAD_F00D);
      // writes in the acceptance cycle are ignored
      run_exc(8'h00, 1'b0, 0, 32'h0000_2000, 1'b0, "R9", 1'b0, 1'b0, 1'b0, 1'b1);
      reg_write(32'hFFFF_FFF0, 1'b1);
      run_exc(8'hFF, 1'b0, 4, 32'hCAFE_0000, 1'b0, "R2", 1'b1, 1'b1, 1'b1, 1'b0);
      run_exc(8'h80, 1'b1, 0, 32'h8000_0000, 1'b1, "R3", 1'b0, 1'b0, 1'b0, 1'b0);
      run_exc(8'h01, 1'b1, 0, 32'h0000_0004, 1'b0, "R3", 1'b0, 1'b0, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule